// File: doc/BRIEF.md
# Configurable Status Pin Driver

This block turns internal link status into two general-purpose status pins. Each pin picks one of four status bits through a 2-bit select code. The chosen bit can be inverted. The pin then leaves through either a push-pull stage or an open-drain stage. Every pin output is a value paired with an output-enable, and the pad cell outside this block turns that pair into a real pin.

One of the four status bits records which port the host sits behind. A start-of-frame pulse seen during high-speed operation updates it: a pulse on the internal port clears the flag, and a pulse on the external port sets it. A strap input says whether the per-pin fields are programmed by software. While the strap is low, the per-pin fields are ignored and fixed defaults take over. All inputs are plain level or pulse signals, and none carry a data stream, so the block has no valid/ready handshake. Outputs are registered, so a change of mode or source shows up on the pins one clock later and never glitches.

Top module: `stat_pin_driver`

## Requirements
- R1: Pin select code 0 chooses the high-speed flag, code 1 chooses the host-port flag, code 2 chooses link state bit 0 and code 3 chooses link state bit 1.
- R2: While high speed is active, an internal-port SOF pulse alone clears the host-port flag to 0 and an external-port SOF pulse alone sets it to 1. Two pulses in the same cycle leave the flag unchanged.
- R3: While high speed is inactive, the host-port flag keeps its value whatever the SOF pulses do. Reset clears the flag to 0.
- R4: In push-pull mode (mode bit 0), oe is 1 and the pin value equals the selected bit XOR the invert bit.
- R5: In open-drain mode (mode bit 1), the pin drives low (oe 1, value 0) when the selected bit XOR the invert bit is 0. Otherwise the pin is released (oe 0, value 0).
- R6: During and right after reset, every pin has oe 0 and value 0, which is high impedance.
- R7: While the strap input is 0, the per-pin select, invert and mode fields have no effect. Pin 1 shows the host-port flag and pin 0 shows the high-speed flag, both inverted and open-drain.
- R8: Pin outputs are registered. A change on the status, mode or select inputs appears on the pins after one clock edge. An SOF pulse reaches a pin that shows the host-port flag after two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_active | input | 1 | High-speed operation flag |
| link_state | input | 2 | Encoded link state |
| sof_int | input | 1 | SOF detected on the internal port (one-cycle pulse) |
| sof_ext | input | 1 | SOF detected on the external port (one-cycle pulse) |
| cfg_en | input | 1 | Strap: 1 uses the per-pin fields, 0 uses the fixed defaults |
| pin_sel | input | 4 | Select code per pin, pin i at bits [2i+1:2i] |
| pin_inv | input | 2 | Invert bit per pin |
| pin_od | input | 2 | Mode bit per pin: 1 open-drain, 0 push-pull |
| pin_val | output | 2 | Registered pin value |
| pin_oe | output | 2 | Registered pin output-enable |

## Verification
The bench pulses SOF on the internal port, on the external port and on both at once, each with high speed active and with it inactive. A tracker that ignored the high-speed qualifier, or that let one port win a tie, would show the wrong host-port flag two cycles later.

The invert bit is swept in both modes. An open-drain stage that mixed up drive-low and release would drive a pin that should be floating.

The strap is dropped while the per-pin fields hold values unlike the defaults. A design that leaked those fields through would show push-pull or non-inverted levels.

Random stimulus also checks the one-cycle latency after every change of select and mode.

// File: rtl/stat_pkg.sv
package stat_pkg;

  typedef enum logic [1:0] {
    SRC_HS   = 2'd0,
    SRC_HOST = 2'd1,
    SRC_ST0  = 2'd2,
    SRC_ST1  = 2'd3
  } stat_src_e;

  typedef struct packed {
    stat_src_e sel;
    logic      inv;
    logic      od;
  } pin_cfg_t;

endpackage

// File: rtl/host_port_tracker.sv
module host_port_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_active,
  input  logic sof_int,
  input  logic sof_ext,
  output logic host_ext
);

  logic upd;
  assign upd = hs_active && (sof_int ^ sof_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   host_ext <= 1'b0;
    else if (upd) host_ext <= sof_ext;
  end

  // R2: a lone external SOF during high speed sets the flag
  a_r2_ext_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_active && sof_ext && !sof_int) |=> host_ext);
  // R2: a lone internal SOF during high speed clears the flag
  a_r2_int_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_active && sof_int && !sof_ext) |=> !host_ext);
  // R3: outside high speed the flag holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_active) |=> $stable(host_ext));

endmodule

// File: rtl/stat_src_mux.sv
module stat_src_mux
  import stat_pkg::*;
(
  input  stat_src_e  sel,
  input  logic       hs_active,
  input  logic       host_ext,
  input  logic [1:0] link_state,
  output logic       status
);

  always_comb begin
    unique case (sel)
      SRC_HS:   status = hs_active;
      SRC_HOST: status = host_ext;
      SRC_ST0:  status = link_state[0];
      SRC_ST1:  status = link_state[1];
      default:  status = 1'b0;
    endcase
  end

endmodule

// File: rtl/stat_out_stage.sv
module stat_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic status,
  input  logic inv,
  input  logic od,
  output logic val,
  output logic oe
);

  logic lvl, val_d, oe_d;

  always_comb begin
    lvl = status ^ inv;
    if (od) begin
      oe_d  = ~lvl;
      val_d = 1'b0;
    end else begin
      oe_d  = 1'b1;
      val_d = lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val <= 1'b0;
      oe  <= 1'b0;
    end else begin
      val <= val_d;
      oe  <= oe_d;
    end
  end

  // R4: push-pull drives the adjusted status one edge later
  a_r4_push_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (!od) |=> (oe && (val == $past(status ^ inv))));
  // R5: open-drain never drives high
  a_r5_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
    od |=> !val);
  // R5: open-drain releases on an adjusted 1
  a_r5_od_release: assert property (@(posedge clk) disable iff (!rst_n)
    (od && (status ^ inv)) |=> !oe);

endmodule

// File: rtl/stat_pin_driver.sv
module stat_pin_driver
  import stat_pkg::*;
#(
  parameter int NPIN = 2,
  parameter logic [2*NPIN-1:0] DEF_SEL = {SRC_HOST, SRC_HS},
  parameter logic [NPIN-1:0]   DEF_INV = '1,
  parameter logic [NPIN-1:0]   DEF_OD  = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hs_active,
  input  logic [1:0]      link_state,
  input  logic            sof_int,
  input  logic            sof_ext,
  input  logic            cfg_en,
  input  logic [2*NPIN-1:0] pin_sel,
  input  logic [NPIN-1:0] pin_inv,
  input  logic [NPIN-1:0] pin_od,
  output logic [NPIN-1:0] pin_val,
  output logic [NPIN-1:0] pin_oe
);

  logic host_ext;

  host_port_tracker u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hs_active(hs_active),
    .sof_int  (sof_int),
    .sof_ext  (sof_ext),
    .host_ext (host_ext)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pin_cfg_t cfg;
    logic     status;

    always_comb begin
      if (cfg_en) begin
        cfg.sel = stat_src_e'(pin_sel[2*i +: 2]);
        cfg.inv = pin_inv[i];
        cfg.od  = pin_od[i];
      end else begin
        cfg.sel = stat_src_e'(DEF_SEL[2*i +: 2]);
        cfg.inv = DEF_INV[i];
        cfg.od  = DEF_OD[i];
      end
    end

    stat_src_mux u_mux (
      .sel       (cfg.sel),
      .hs_active (hs_active),
      .host_ext  (host_ext),
      .link_state(link_state),
      .status    (status)
    );

    stat_out_stage u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .status(status),
      .inv   (cfg.inv),
      .od    (cfg.od),
      .val   (pin_val[i]),
      .oe    (pin_oe[i])
    );
  end

  // R7: with the strap low, pin 0 follows the HS flag in inverted open-drain
  a_r7_strap_pin0: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en) |=> (!pin_val[0] && (pin_oe[0] == $past(hs_active))));
  // R6: the value bit never rises while the output is released
  a_r6_released_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_oe[0]) |-> !pin_val[0]);

endmodule

// File: tb/sim_stat_pin_driver.sv
module sim_stat_pin_driver;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs_active = 1'b0;
  logic [1:0] link_state = 2'b00;
  logic       sof_int = 1'b0, sof_ext = 1'b0, cfg_en = 1'b0;
  logic [3:0] pin_sel = 4'h0;
  logic [1:0] pin_inv = 2'b00, pin_od = 2'b00;
  logic [1:0] pin_val, pin_oe;

  int n_run = 0, n_fail = 0;
  logic hp_m = 1'b0;
  logic [1:0] exp_val, exp_oe;

  always #10 clk = ~clk;

  stat_pin_driver u0 (
    .clk(clk), .rst_n(rst_n), .hs_active(hs_active), .link_state(link_state),
    .sof_int(sof_int), .sof_ext(sof_ext), .cfg_en(cfg_en), .pin_sel(pin_sel),
    .pin_inv(pin_inv), .pin_od(pin_od), .pin_val(pin_val), .pin_oe(pin_oe)
  );

  function automatic logic pick(input logic [1:0] s, input logic hs,
                                input logic hp, input logic [1:0] st);
    case (s)
      2'd0: return hs;
      2'd1: return hp;
      2'd2: return st[0];
      default: return st[1];
    endcase
  endfunction

  task automatic check(input string tag, input int p);
    n_run++;
    if (pin_val[p] !== exp_val[p] || pin_oe[p] !== exp_oe[p]) begin
      n_fail++;
      $display("FAIL %s pin%0d: val/oe actual %b/%b expected %b/%b",
               tag, p, pin_val[p], pin_oe[p], exp_val[p], exp_oe[p]);
    end
  endtask

  // Apply the current inputs over one edge and check both pins.
  task automatic step(input string tag);
    for (int p = 0; p < 2; p++) begin
      logic [1:0] s;
      logic i, o, st, l;
      s = cfg_en ? pin_sel[2*p +: 2] : ((p == 1) ? 2'd1 : 2'd0);
      i = cfg_en ? pin_inv[p] : 1'b1;
      o = cfg_en ? pin_od[p]  : 1'b1;
      st = pick(s, hs_active, hp_m, link_state);
      l = st ^ i;
      exp_oe[p]  = o ? ~l : 1'b1;
      exp_val[p] = o ? 1'b0 : l;
    end
    if (hs_active && (sof_int ^ sof_ext)) hp_m = sof_ext;
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < 2; p++) check(tag, p);
    sof_int = 1'b0;
    sof_ext = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    exp_val = 2'b00; exp_oe = 2'b00;
    check("R6 reset", 0); check("R6 reset", 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 after reset", 0); check("R6 after reset", 1);

    // R7 defaults, with contrary per-pin fields held
    pin_sel = 4'b1110; pin_inv = 2'b00; pin_od = 2'b00; cfg_en = 1'b0;
    hs_active = 1'b1; step("R7 hs=1");
    hs_active = 1'b0; step("R7 hs=0");

    // R3 reset value of host flag, R1 code1 push-pull
    cfg_en = 1'b1; pin_sel = 4'b0101; pin_inv = 2'b00; pin_od = 2'b00;
    step("R3 reset flag");
    // R2 external SOF during HS: flag seen two edges later (R8)
    hs_active = 1'b1; sof_ext = 1'b1; step("R8 first edge");
    step("R2 ext sets");
    sof_int = 1'b1; sof_ext = 1'b1; step("R2 tie"); step("R2 tie hold");
    sof_int = 1'b1; step("R2 int"); step("R2 int clears");
    hs_active = 1'b0; sof_ext = 1'b1; step("R3 no hs"); step("R3 held");
    // R1 codes 2 and 3, R5 open-drain with both invert values
    link_state = 2'b10; pin_sel = 4'b1110; pin_od = 2'b11;
    pin_inv = 2'b00; step("R1 R5 no inv");
    pin_inv = 2'b11; step("R1 R5 inv");
    pin_od = 2'b00; step("R1 R4 inv");

    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      hs_active = r[0]; link_state = r[2:1]; sof_int = r[3]; sof_ext = r[4];
      cfg_en = r[5] | r[6]; pin_sel = r[10:7]; pin_inv = r[12:11];
      pin_od = r[14:13];
      step(!cfg_en ? "R7 random" : (pin_od != 0 ? "R1 R2 R5 random" : "R1 R2 R4 random"));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule